// File: doc/BRIEF.md
# MSI Message Ring Writer

This block takes message-signalled interrupt writes, each one a 32-bit data word, and stores each as a 16-byte entry in a circular buffer in host memory. Software programs a 64-bit base address and a ring size. It then reads entries from the ring and moves a read offset forward. The block issues one memory write per stored message on a request/ready port. It holds an interrupt level high while the ring holds entries that software has not read.

The producer offset is a free-running byte count and is never wrapped. Software must reduce it modulo the ring size before comparing it with its own read offset. An optional full detector can be enabled. With stop-on-full also set, the block drops messages that would fill the ring and counts them. With stop-on-full clear, the block overwrites the oldest entries.

Top module: `msi_ring_writer`

## Requirements
- R1: Register map, decoded on `reg_addr`, with `reg_rdata` a combinational function of `reg_addr`:
  - 0: control
  - 3: base address bits 63:32
  - 4: base address bits 31:0
  - 5: read offset
  - 6: write offset (read-only)
  - 7: drop count (read-only)
  - Unmapped addresses read as zero.
- R2: Control bits:
  - bit 0: capture enable
  - bit 1: full detection enable
  - bit 3: interrupt enable
  - bit 4: stop-on-full
  - bits 9:8: ring size code
  - Only these bits are stored; all other bits read back as zero.
- R3: The ring size is 2^(15+code) bytes (32 KB to 256 KB). A value written to the read offset is reduced to a 16-byte-aligned offset inside the current ring.
- R4: Each stored message produces one memory write:
  - `mem_addr` is the base address plus (write offset modulo ring size).
  - `mem_data[31:0]` carries the message word (byte 0 = bits 7:0).
  - `mem_data[127:32]` is zero.
- R5: The write offset increases by 16 only on the cycle `mem_req` and `mem_ready` are both high. It is never wrapped to the ring size. While `mem_ready` is low, `mem_req` and `mem_addr` hold their values.
- R6: `irq` is high exactly when interrupt enable is set and (write offset modulo ring size) differs from the read offset.
- R7: With capture enable clear, offered messages are consumed and discarded. No memory write is issued and the write offset does not change.
- R8: A register write to either base address register clears both the read and write offsets to zero.
- R9: The ring is full when ((write offset mod size) + 16) mod size equals the read offset and full detection is on. A message arriving while full with stop-on-full set is not written and increments the drop count. With stop-on-full clear, the message is written, overwriting the oldest entry.
- R10: At most one memory write is outstanding. `msi_ready` is low while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| msi_valid | input | 1 | Message offered |
| msi_data | input | 32 | Message data word |
| msi_ready | output | 1 | Block can take a message |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory byte address of the entry |
| mem_data | output | 128 | Entry contents |
| mem_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Unread-entries interrupt level |

## Verification
The following properties are checked on every cycle:
- A request holds steady while it is stalled, and only one write is ever outstanding.
- The write offset stays 16-byte aligned and moves only after a completed write or a base-address write.
- The interrupt is never high without its enable.
- No write is started while capture is disabled.

Some behaviours can only be shown by the bench's scenarios:
- The entry address and contents.
- The unwrapped offset passing the ring size.
- The read-offset masking for different size codes.
- The exact full point, with drops under stop-on-full and overwrite without it.

// File: rtl/msi_ring_writer.sv
module msi_ring_writer #(
  parameter int OFF_W  = 32,
  parameter int DROP_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         msi_valid,
  input  logic [31:0]  msi_data,
  output logic         msi_ready,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  input  logic         mem_ready,
  output logic         irq
);
  localparam int          ENTRY     = 16;
  localparam logic [9:0]  CTRL_BITS = 10'h31B;
  localparam logic [OFF_W-1:0] MIN_RING = OFF_W'(32'h8000);

  logic [9:0]        ctrl_q;
  logic [31:0]       base_hi_q, base_lo_q, data_q;
  logic [63:0]       addr_q;
  logic [OFF_W-1:0]  roff_q, woff_q;
  logic [DROP_W-1:0] drop_q;
  logic              busy_q;

  logic [OFF_W-1:0] ring_mask, wr_pos, next_pos;
  logic             ring_full, take, base_wr;

  assign ring_mask = ((MIN_RING << ctrl_q[9:8]) - OFF_W'(1)) & ~OFF_W'(15);
  assign wr_pos    = woff_q & ring_mask;
  assign next_pos  = (wr_pos + OFF_W'(ENTRY)) & ring_mask;
  assign ring_full = ctrl_q[1] && (next_pos == roff_q);
  assign take      = msi_valid && msi_ready && ctrl_q[0];
  assign base_wr   = reg_wr && (reg_addr == 3'd3 || reg_addr == 3'd4);

  assign msi_ready = !busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = addr_q;
  assign mem_data  = {96'b0, data_q};
  assign irq       = ctrl_q[3] && (wr_pos != roff_q);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {22'b0, ctrl_q};
      3'd3:    reg_rdata = base_hi_q;
      3'd4:    reg_rdata = base_lo_q;
      3'd5:    reg_rdata = 32'(roff_q);
      3'd6:    reg_rdata = 32'(woff_q);
      3'd7:    reg_rdata = 32'(drop_q);
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      roff_q    <= '0;
      woff_q    <= '0;
      drop_q    <= '0;
      busy_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (busy_q && mem_ready) begin
        busy_q <= 1'b0;
        woff_q <= woff_q + OFF_W'(ENTRY);
      end
      if (take) begin
        if (ring_full && ctrl_q[4]) begin
          drop_q <= drop_q + DROP_W'(1);
        end else begin
          busy_q <= 1'b1;
          addr_q <= {base_hi_q, base_lo_q} + 64'(wr_pos);
          data_q <= msi_data;
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: ctrl_q    <= reg_wdata[9:0] & CTRL_BITS;
          3'd3: base_hi_q <= reg_wdata;
          3'd4: base_lo_q <= reg_wdata;
          3'd5: roff_q    <= OFF_W'(reg_wdata) & ring_mask;
          default: ;
        endcase
      end
      if (base_wr) begin
        woff_q <= '0;
        roff_q <= '0;
      end
    end
  end
endmodule

// File: rtl/msi_ring_writer_chk.sv
module msi_ring_writer_chk #(
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             msi_ready,
  input logic             mem_req,
  input logic             mem_ready,
  input logic [63:0]      mem_addr,
  input logic             irq,
  input logic [9:0]       ctrl_q,
  input logic [OFF_W-1:0] woff_q
);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !msi_ready);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  // R5
  woff_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    woff_q[3:0] == 4'b0);

  // R8
  woff_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(woff_q) |-> $past(mem_req && mem_ready)
      || $past(reg_wr && (reg_addr == 3'd3 || reg_addr == 3'd4)));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[3]);

  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] && !mem_req |=> !mem_req);
endmodule

bind msi_ring_writer msi_ring_writer_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .msi_ready(msi_ready), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .irq(irq), .ctrl_q(ctrl_q), .woff_q(woff_q)
);

// File: tb/msi_ring_writer_bench.sv
module msi_ring_writer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic msi_valid = 1'b0, msi_ready;
  logic [31:0] msi_data = 32'd0;
  logic mem_req, mem_ready = 1'b1, irq;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_2000_0000;
  localparam logic [31:0] MSGS [4] = '{32'h0000_0042, 32'hDEAD_0017, 32'h1234_FFFF, 32'h0000_0001};
  localparam logic [31:0] OFFS [4] = '{32'h10, 32'h20, 32'h30, 32'h40};

  always #2 clk = ~clk;

  msi_ring_writer u_msi_ring_writer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_data(msi_data), .msi_ready(msi_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] d, output bit got, output logic [63:0] a, output logic [127:0] q);
    @(negedge clk); msi_valid = 1'b1; msi_data = d;
    @(negedge clk); msi_valid = 1'b0;
    got = mem_req; a = mem_addr; q = mem_data;
    if (mem_ready) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    bit g;
    logic [63:0] a;
    logic [127:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset mem_req", mem_req, 0);
    check("R6 reset irq", irq, 0);
    rd(3'd6, r); check("R1 reset woff", r, 0);

    wr(3'd0, 32'hFFFF_F40B);
    rd(3'd0, r); check("R2 ctrl readback", r, 32'h0000_000B);
    wr(3'd3, BASE[63:32]); wr(3'd4, BASE[31:0]);
    rd(3'd3, r); check("R1 base hi", r, BASE[63:32]);
    rd(3'd2, r); check("R1 unmapped", r, 0);

    for (int i = 0; i < 4; i++) begin
      send(MSGS[i], g, a, q);
      check("R4 req", g, 1);
      check("R4 addr", a, BASE + 64'(i * 16));
      check("R4 data", q, {96'b0, MSGS[i]});
      rd(3'd6, r); check("R5 woff", r, OFFS[i]);
      check("R6 irq pending", irq, 1);
    end

    wr(3'd5, 32'h40); @(negedge clk); check("R6 irq caught up", irq, 0);
    wr(3'd5, 32'h10); @(negedge clk); check("R6 irq behind", irq, 1);
    wr(3'd0, 32'h03); @(negedge clk); check("R6 irq disabled", irq, 0);

    wr(3'd0, 32'h0B);
    mem_ready = 1'b0;
    send(32'h55, g, a, q);
    repeat (4) @(negedge clk);
    check("R10 stall req", mem_req, 1);
    check("R10 stall ready", msi_ready, 0);
    check("R5 stall addr", mem_addr, BASE + 64'h40);
    rd(3'd6, r); check("R5 stall woff", r, 32'h40);
    mem_ready = 1'b1;
    @(negedge clk);
    rd(3'd6, r); check("R5 after handshake", r, 32'h50);

    wr(3'd0, 32'h08);
    send(32'h66, g, a, q);
    check("R7 no req", g, 0);
    rd(3'd6, r); check("R7 woff", r, 32'h50);

    wr(3'd4, BASE[31:0]);
    rd(3'd6, r); check("R8 woff clear", r, 0);
    rd(3'd5, r); check("R8 roff clear", r, 0);

    wr(3'd0, 32'h30B); wr(3'd5, 32'h3FFF5);
    rd(3'd5, r); check("R3 256K mask", r, 32'h3FFF0);
    wr(3'd0, 32'h01B); wr(3'd5, 32'h3FFF0);
    rd(3'd5, r); check("R3 32K mask", r, 32'h7FF0);

    for (int i = 0; i < 2046; i++) send(32'(i), g, a, q);
    rd(3'd6, r); check("R9 fill woff", r, 32'h7FE0);
    send(32'h77, g, a, q);
    check("R9 drop no req", g, 0);
    rd(3'd7, r); check("R9 drop count", r, 1);
    rd(3'd6, r); check("R9 woff after drop", r, 32'h7FE0);

    wr(3'd0, 32'h00B);
    send(32'h88, g, a, q); check("R9 overwrite addr", a, BASE + 64'h7FE0);
    check("R6 irq at full", irq, 0);
    send(32'h99, g, a, q); check("R9 last slot", a, BASE + 64'h7FF0);
    rd(3'd6, r); check("R5 unwrapped woff", r, 32'h8000);
    check("R6 irq after wrap", irq, 1);
    send(32'hAA, g, a, q); check("R4 wrapped addr", a, BASE);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule